// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a management-interface master that performs one clause-22 PHY register read or write per command. Software first places the 16-bit write value in the data register. It then writes the command register with the PHY address, the register number, a direction flag, a start flag and a clock-ratio code. The engine derives the management clock (MDC) from the host clock and serialises a 64-bit frame on the management data line. When the frame is over, it clears the start flag, which software then reads back as busy.

On a read, the engine releases the data line for the turnaround and the data bits. It shifts in what the PHY returns on each rising MDC edge and moves the 16-bit result into the data register at completion. A bit in the control register gates MDC. While that bit is low, MDC is held low and any pending frame waits. The register port is a plain strobe with an address and no back-pressure: a write is taken in the cycle it is presented, and the read views are always live.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, MDC is low, the data-line output enable is low, and the command readback, data readback and MDC-enable readback are all zero.
- R2: Command register field layout (address 1): register number in bits 4:0, PHY address in bits 12:8, write flag in bit 16 (1 means write), start/busy in bit 17, ratio code in bits 23:20. Writing it with bit 17 set while idle starts a frame and makes bit 17 read back 1.
- R3: A write frame carries, MSB first, one bit per MDC period: 32 ones, 01, 01, five PHY-address bits, five register bits, 10, then the 16 data-register bits. The line is driven throughout and changes only after a falling MDC edge.
- R4: A read frame carries 32 ones, 01, 10 and the address bits. The output enable is low for the last 18 bit periods. The 16 bits that the PHY presents at the rising MDC edges of the data phase appear, MSB first, in the data register (address 2) after completion.
- R5: Ratio codes 0 to 15 give an MDC period of 4, 6, 8, 12, 16, 20, 24, 28, 30, 32, 36, 40, 44, 48, 54 and 60 host clocks.
- R6: Busy clears on the host clock edge where MDC falls after the 64th rising edge of the frame, and the output enable is low from that edge on.
- R7: A command-register write that arrives while busy is set is ignored: the frame in progress is unchanged and the command readback keeps its earlier fields.
- R8: MDC stays low while the MDC-enable bit (control register, address 0, bit 19) is clear. A command issued in that state stays busy and runs once the bit is set.
- R9: A command-register write with bit 17 clear updates the stored fields but starts no frame: busy stays 0 and the output enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 command, 2 data |
| reg_wdata | input | 24 | Register write value |
| ctl_mdc_en | output | 1 | Readback of the MDC-enable bit |
| cmd_rdata | output | 24 | Command register readback, bit 17 is busy |
| dat_rdata | output | 16 | Data register readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Busy shows one clock after the command strobe. The first frame bit appears at the first falling MDC edge after that and is observed at the next rising edge. A frame therefore spans 64 MDC periods plus up to one period of alignment. The bench samples on the falling host-clock edge and detects MDC transitions by comparing with the previous sample. It records each bit, its enable and its clock index at every rising MDC. It requires busy and enable to be low at exactly the sample where MDC falls after the 64th rise. Read data is presented just after each MDC fall, so the bit is stable at the following rise.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN  = 64;
  localparam int IDX_W      = $clog2(FRAME_LEN);
  localparam int RELEASE_AT = 46;
  localparam int DATA_AT    = 48;
  localparam int HALF_W     = 5;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ALIGN, SQ_RUN} sq_state_e;

  function automatic logic [HALF_W-1:0] half_period(input logic [3:0] code);
    case (code)
      4'd0:  half_period = 5'd2;
      4'd1:  half_period = 5'd3;
      4'd2:  half_period = 5'd4;
      4'd3:  half_period = 5'd6;
      4'd4:  half_period = 5'd8;
      4'd5:  half_period = 5'd10;
      4'd6:  half_period = 5'd12;
      4'd7:  half_period = 5'd14;
      4'd8:  half_period = 5'd15;
      4'd9:  half_period = 5'd16;
      4'd10: half_period = 5'd18;
      4'd11: half_period = 5'd20;
      4'd12: half_period = 5'd22;
      4'd13: half_period = 5'd24;
      4'd14: half_period = 5'd27;
      default: half_period = 5'd30;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise,
  output logic              fall
);
  logic [HALF_W-1:0] cnt_q;
  logic              term;

  assign term = en && (cnt_q >= half - 1'b1);
  assign rise = term && !mdc;
  assign fall = term && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8: gated clock stays low
  a_r8_mdc_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);
  a_r5_rise_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $past(en));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_wr,
  input  logic [4:0]  phy,
  input  logic [4:0]  regn,
  input  logic [15:0] wdata,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rdata
);
  sq_state_e            st_q;
  logic [FRAME_LEN-1:0] sh_q;
  logic [FRAME_LEN-1:0] frame;
  logic [IDX_W-1:0]     idx_q;
  logic                 wr_q;
  logic [4:0]           phy_q, reg_q;
  logic [15:0]          wd_q, rx_q;

  assign frame = {{32{1'b1}}, 2'b01, (wr_q ? 2'b01 : 2'b10), phy_q, reg_q,
                  (wr_q ? 2'b10 : 2'b00), (wr_q ? wd_q : 16'h0000)};

  assign done    = (st_q == SQ_RUN) && fall && (idx_q == IDX_W'(FRAME_LEN-1));
  assign mdio_o  = (st_q == SQ_RUN) ? sh_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe = (st_q == SQ_RUN) && (wr_q || idx_q < IDX_W'(RELEASE_AT));
  assign rdata   = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      sh_q  <= '0;
      idx_q <= '0;
      wr_q  <= 1'b0;
      phy_q <= '0;
      reg_q <= '0;
      wd_q  <= '0;
      rx_q  <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (start) begin
          st_q  <= SQ_ALIGN;
          wr_q  <= is_wr;
          phy_q <= phy;
          reg_q <= regn;
          wd_q  <= wdata;
        end
        SQ_ALIGN: if (fall) begin
          st_q  <= SQ_RUN;
          sh_q  <= frame;
          idx_q <= '0;
        end
        default: begin
          if (rise && !wr_q && idx_q >= IDX_W'(DATA_AT))
            rx_q <= {rx_q[14:0], mdio_i};
          if (fall) begin
            if (idx_q == IDX_W'(FRAME_LEN-1)) begin
              st_q <= SQ_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
              sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b0};
            end
          end
        end
      endcase
    end
  end

  // R3: driven bit changes only at an MDC fall
  a_r3_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_RUN && !fall) |=> $stable(idx_q));
  // R4: a read releases the line before data comes back
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !wr_q && st_q == SQ_RUN && idx_q >= IDX_W'(DATA_AT)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int REG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic             ctl_mdc_en,
  output logic [REG_W-1:0] cmd_rdata,
  output logic [15:0]      dat_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_CMD = 2'd1;
  localparam logic [1:0] A_DAT = 2'd2;
  localparam int BUSY_B = 17;
  localparam int WR_B   = 16;
  localparam int EN_B   = 19;

  logic [REG_W-1:0] cmd_q;
  logic [15:0]      dat_q;
  logic             en_q;
  logic             busy, accept, seq_done, rise, fall;
  logic [15:0]      rd_word;

  assign busy       = cmd_q[BUSY_B];
  assign accept     = reg_wr && reg_addr == A_CMD && reg_wdata[BUSY_B] && !busy;
  assign ctl_mdc_en = en_q;
  assign cmd_rdata  = cmd_q;
  assign dat_rdata  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      dat_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTL) en_q <= reg_wdata[EN_B];
      if (reg_wr && reg_addr == A_CMD && !busy) cmd_q <= reg_wdata;
      if (reg_wr && reg_addr == A_DAT) dat_q <= reg_wdata[15:0];
      if (seq_done) begin
        cmd_q[BUSY_B] <= 1'b0;
        if (!cmd_q[WR_B]) dat_q <= rd_word;
      end
    end
  end

  mdio_clk_gen i_clk (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en_q),
    .half (half_period(cmd_q[23:20])),
    .mdc  (mdc),
    .rise (rise),
    .fall (fall)
  );

  mdio_frame_seq i_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .is_wr  (reg_wdata[WR_B]),
    .phy    (reg_wdata[12:8]),
    .regn   (reg_wdata[4:0]),
    .wdata  (dat_q),
    .rise   (rise),
    .fall   (fall),
    .mdio_i (mdio_i),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe),
    .done   (seq_done),
    .rdata  (rd_word)
  );

  // R7: a command write during busy leaves the stored command intact
  a_r7_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == A_CMD) |=> $stable(cmd_q[12:0]));
  // R6: line released once busy drops
  a_r6_release_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !mdio_oe);
  // R9: no drive without a pending command
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
  // R2: busy rises only on a start request
  a_r2_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_wdata[BUSY_B]));
endmodule

// File: tb/test_mdio_cmd_engine.sv
module test_mdio_cmd_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [23:0] reg_wdata = '0;
  logic        mdio_i = 1'b1;
  logic        ctl_mdc_en, mdc, mdio_o, mdio_oe;
  logic [23:0] cmd_rdata;
  logic [15:0] dat_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [63:0] cap, oecap;
  int          rt0, rt1;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_cmd_engine i_mdio_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ctl_mdc_en(ctl_mdc_en), .cmd_rdata(cmd_rdata),
    .dat_rdata(dat_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ratio(input int code);
    int t[16] = '{4, 6, 8, 12, 16, 20, 24, 28, 30, 32, 36, 40, 44, 48, 54, 60};
    return t[code];
  endfunction

  function automatic logic [63:0] frame(input bit wr, input logic [4:0] p,
                                        input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r,
            (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0)};
  endfunction

  task automatic wreg(input logic [1:0] a, input logic [23:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [23:0] cmdw(input int code, input bit wr, input bit go,
                                       input logic [4:0] p, input logic [4:0] r);
    return {4'(code), 2'b00, go, wr, 3'b000, p, 3'b000, r};
  endfunction

  // Watches one frame; optional intrusion of a command write at rise 10.
  task automatic watch(input logic [15:0] rdval, input bit intrude,
                       input logic [23:0] icmd, output bit ended_ok);
    bit started = 0, prev, pend = 0;
    int nr = 0, t0 = cyc;
    ended_ok = 0;
    prev = mdc;
    forever begin
      @(negedge clk);
      if (pend) begin reg_wr = 1'b0; pend = 0; end
      if (mdc && !prev) begin
        if (!started && mdio_oe) started = 1;
        if (started && nr < 64) begin
          cap[63-nr] = mdio_o; oecap[63-nr] = mdio_oe;
          if (nr == 0) rt0 = cyc;
          if (nr == 1) rt1 = cyc;
          nr++;
          if (intrude && nr == 10) begin
            reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = icmd; pend = 1;
          end
        end
      end
      if (!mdc && prev && started) begin
        if (nr == 64) begin
          // R6: busy and enable drop at this very fall
          check(cmd_rdata[17] == 1'b0 && mdio_oe == 1'b0, "R6",
                {cmd_rdata[17], mdio_oe}, 0);
          ended_ok = 1;
          mdio_i = 1'b1;
          return;
        end
        mdio_i = (nr >= 48) ? rdval[63-nr] : 1'b1;
      end
      prev = mdc;
      if (cyc - t0 > 6000) return;
    end
  endtask

  task automatic run_wr(input int code, input logic [4:0] p, input logic [4:0] r,
                        input logic [15:0] d);
    bit ok;
    wreg(2'd2, {8'h00, d});
    wreg(2'd1, cmdw(code, 1, 1, p, r));
    check(cmd_rdata[17] == 1'b1, "R2", cmd_rdata, 24'h020000);
    watch(16'h0, 0, 24'h0, ok);
    check(ok && cap == frame(1, p, r, d), "R3", cap, frame(1, p, r, d));
    check(rt1 - rt0 == ratio(code), "R5", rt1 - rt0, ratio(code));
  endtask

  task automatic run_rd(input int code, input logic [4:0] p, input logic [4:0] r,
                        input logic [15:0] v);
    bit ok;
    logic [63:0] e;
    e = frame(0, p, r, 16'h0);
    wreg(2'd1, cmdw(code, 0, 1, p, r));
    watch(v, 0, 24'h0, ok);
    check(ok && cap[63:18] == e[63:18], "R4 frame", cap, e);
    check(oecap == {{46{1'b1}}, 18'h0}, "R4 release", oecap, {{46{1'b1}}, 18'h0});
    @(negedge clk);
    check(dat_rdata == v, "R4 data", dat_rdata, v);
    check(rt1 - rt0 == ratio(code), "R5", rt1 - rt0, ratio(code));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    bit ok;
    logic [23:0] c0;
    repeat (3) @(negedge clk);
    check(mdc == 0 && mdio_oe == 0 && cmd_rdata == 0 && dat_rdata == 0 && ctl_mdc_en == 0,
          "R1", {mdc, mdio_oe, ctl_mdc_en, cmd_rdata, dat_rdata}, 0);
    rst_n = 1'b1;
    // R8: clock held low while disabled
    begin
      bit seen = 0;
      repeat (50) begin @(negedge clk); if (mdc) seen = 1; end
      check(!seen, "R8 idle low", seen, 0);
    end
    wreg(2'd0, 24'h080000);
    check(ctl_mdc_en == 1'b1, "R8 enable readback", ctl_mdc_en, 1);
    // R9: command without start bit
    begin
      bit drv = 0;
      wreg(2'd1, cmdw(3, 1, 0, 5'h0A, 5'h05));
      repeat (300) begin @(negedge clk); if (mdio_oe || cmd_rdata[17]) drv = 1; end
      check(!drv, "R9 no frame", drv, 0);
      check(cmd_rdata == cmdw(3, 1, 0, 5'h0A, 5'h05), "R9 fields", cmd_rdata,
            cmdw(3, 1, 0, 5'h0A, 5'h05));
    end
    // R3/R5: write sweep over every ratio code
    for (int k = 0; k < 16; k++)
      run_wr(k, 5'(k * 3 + 1), 5'(31 - k), 16'(16'hA5C3 ^ (k * 16'h1111)));
    // R4/R5: read sweep over every ratio code
    for (int k = 0; k < 16; k++)
      run_rd(k, 5'(k + 7), 5'(k * 5), 16'(16'h8001 + k * 16'h0F3B));
    run_rd(0, 5'h1F, 5'h1F, 16'hFFFF);
    run_rd(0, 5'h00, 5'h00, 16'h0000);
    // R7: command during busy is ignored
    c0 = cmdw(1, 1, 1, 5'h11, 5'h06);
    wreg(2'd2, 24'h00_3C5A);
    wreg(2'd1, c0);
    watch(16'h0, 1, cmdw(2, 0, 1, 5'h02, 5'h19), ok);
    check(ok && cap == frame(1, 5'h11, 5'h06, 16'h3C5A), "R7 frame", cap,
          frame(1, 5'h11, 5'h06, 16'h3C5A));
    check(cmd_rdata[12:0] == c0[12:0], "R7 fields", cmd_rdata, c0);
    // R8: command while disabled waits, then runs
    wreg(2'd0, 24'h000000);
    wreg(2'd1, cmdw(0, 1, 1, 5'h03, 5'h04));
    begin
      bit bad = 0;
      repeat (300) begin @(negedge clk); if (mdc || !cmd_rdata[17]) bad = 1; end
      check(!bad, "R8 stalled", bad, 0);
    end
    wreg(2'd0, 24'h080000);
    watch(16'h0, 0, 24'h0, ok);
    check(ok && cap == frame(1, 5'h03, 5'h04, 16'h3C5A), "R8 resumed", cap,
          frame(1, 5'h03, 5'h04, 16'h3C5A));
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule